// File: doc/BRIEF.md
# Raster Timing Generator for a Parallel RGB Panel

This block turns a handful of programmed numbers into the sync and data-enable strobes that a parallel RGB panel expects, together with the column and row position of the pixel being shown. Software sets the active width and height, the line and frame totals, the sync pulse widths and the sync-plus-back-porch offsets through a small 32-bit write/read register port. The raster then runs on the pixel clock once two separate enable bits are both set.

Two conventions shape the programming model. First, each back-porch offset is measured from the start of the sync pulse, so it already contains the pulse width. Second, the frame-total field holds twice the real number of lines, and the block halves it internally. Timing fields are copied into working registers only at a frame boundary, or at any time while the raster is stopped. A sticky vertical-blank status bit, gated by its own enable, drives a single interrupt line. One tristate control bit decides whether the panel pins are driven.

Top module: `lcd_timing_ctrl`

## Requirements
- R1: After reset the global enable, channel enable, interrupt enable and blank status read 0, the tristate register (word 7, bit 0) reads 1, and `lcd_de`, `pad_oe` and `irq_o` are 0.
- R2: The raster runs only while both global enable (word 0, bit 0) and channel enable (word 1, bit 0) are 1; otherwise the counters sit at 0, `lcd_de` is 0 and both syncs are at their inactive level.
- R3: Within a line of `htotal` pixels (word 3, bits 15:0), the horizontal sync is active for counts below the sync width (word 5, bits 15:0), and data is enabled from count `hbp` (word 3, bits 31:16) for `width` pixels (word 2, bits 15:0).
- R4: The frame has (word 4, bits 15:0) / 2 lines; vertical sync is active for lines below the vsync width (word 5, bits 31:16); active lines start at `vbp` (word 4, bits 31:16) and run for `height` lines (word 2, bits 31:16).
- R5: While `lcd_de` is 1, `pix_x`/`pix_y` give the offset from the first active pixel/line; otherwise both are 0.
- R6: Word 6, bit 0 inverts `lcd_hsync` and bit 1 inverts `lcd_vsync`, taking effect on the next cycle.
- R7: `pad_oe` is the inverse of the tristate bit (word 7, bit 0).
- R8: Blank status (word 8, bit 8) is set at pixel 0 of line `vbp+height` and stays set; a write to word 8 with bit 8 at 0 clears it, a write with bit 8 at 1 leaves it unchanged; setting wins over clearing.
- R9: `irq_o` equals blank status AND the interrupt enable (word 8, bit 0).
- R10: Writes to words 2 to 5 do not change the raster until the frame in progress has ended.
- R11: Word 1 bits 8:4 hold a 5-bit clock-delay value that reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| lcd_hsync | output | 1 | Horizontal sync after polarity |
| lcd_vsync | output | 1 | Vertical sync after polarity |
| lcd_de | output | 1 | Data enable |
| pix_x | output | CNT_W | Active column |
| pix_y | output | CNT_W | Active row |
| pad_oe | output | 1 | Drive enable for the panel pins |
| irq_o | output | 1 | Vertical-blank interrupt |

## Verification
The bench builds the block with the default counter width of 12. It programs a tiny raster: 10 pixels per line, 8 lines per frame, and a 4x3 active window. This keeps a whole frame within 80 cycles, so many frame wraps, blank events and a mid-frame reprogramming of width and line length happen within a short run. Small porch and sync values put every region edge, including the one-pixel gaps between sync, back porch, active video and front porch, under the per-cycle comparison.

// File: rtl/ltc_pkg.sv
package ltc_pkg;

   localparam int ADDR_W  = 4;
   localparam int FIELD_W = 16;

   typedef enum logic [ADDR_W-1:0] {
      A_GLOBAL = 4'd0,
      A_CHAN   = 4'd1,
      A_ACTIVE = 4'd2,
      A_HTIM   = 4'd3,
      A_VTIM   = 4'd4,
      A_SYNC   = 4'd5,
      A_POL    = 4'd6,
      A_TRI    = 4'd7,
      A_INT    = 4'd8
   } reg_addr_e;

   typedef struct packed {
      logic [FIELD_W-1:0] width;
      logic [FIELD_W-1:0] height;
      logic [FIELD_W-1:0] htotal;
      logic [FIELD_W-1:0] hbp;
      logic [FIELD_W-1:0] vtotal;
      logic [FIELD_W-1:0] vbp;
      logic [FIELD_W-1:0] hsw;
      logic [FIELD_W-1:0] vsw;
   } raster_t;

endpackage

// File: rtl/ltc_axis.sv
module ltc_axis
   import ltc_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               step,
   input  logic [FIELD_W-1:0] total,
   input  logic [FIELD_W-1:0] bp,
   input  logic [FIELD_W-1:0] act_len,
   input  logic [FIELD_W-1:0] sync_len,
   output logic [CNT_W-1:0]   cnt,
   output logic               last,
   output logic               in_sync,
   output logic               in_act,
   output logic [CNT_W-1:0]   pos
);

   localparam int CW = FIELD_W + 1;

   logic [CW-1:0] c_w;
   logic [CW-1:0] start_w;
   logic [CW-1:0] stop_w;

   assign c_w     = CW'(cnt);
   assign start_w = CW'(bp);
   assign stop_w  = CW'(bp) + CW'(act_len);

   assign last    = (c_w + CW'(1)) >= CW'(total);
   assign in_sync = run && (c_w < CW'(sync_len));
   assign in_act  = run && (c_w >= start_w) && (c_w < stop_w);
   assign pos     = in_act ? CNT_W'(c_w - start_w) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt <= '0;
      else if (!run)   cnt <= '0;
      else if (step)   cnt <= last ? '0 : cnt + 1'b1;
   end

endmodule

// File: rtl/ltc_regs.sv
module ltc_regs
   import ltc_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   input  logic              load,
   input  logic              blank_set,
   output raster_t           sh,
   output logic              g_en,
   output logic              c_en,
   output logic              pol_h,
   output logic              pol_v,
   output logic              tri_st,
   output logic              int_en,
   output logic              int_stat
);

   localparam logic [FIELD_W-1:0] MASK   = FIELD_W'((32'd1 << CNT_W) - 1);
   localparam logic [FIELD_W-1:0] MASK_V = FIELD_W'((32'd1 << (CNT_W + 1)) - 1);

   raster_t    lv;
   logic [4:0] clk_dly;
   logic       int_clr;

   assign int_clr = wr && (addr == A_INT) && !wdata[8];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lv      <= '0;
         g_en    <= 1'b0;
         c_en    <= 1'b0;
         clk_dly <= '0;
         pol_h   <= 1'b0;
         pol_v   <= 1'b0;
         tri_st  <= 1'b1;
         int_en  <= 1'b0;
      end else if (wr) begin
         case (addr)
            A_GLOBAL: g_en <= wdata[0];
            A_CHAN: begin
               c_en    <= wdata[0];
               clk_dly <= wdata[8:4];
            end
            A_ACTIVE: begin
               lv.width  <= wdata[15:0] & MASK;
               lv.height <= wdata[31:16] & MASK;
            end
            A_HTIM: begin
               lv.htotal <= wdata[15:0] & MASK;
               lv.hbp    <= wdata[31:16] & MASK;
            end
            A_VTIM: begin
               lv.vtotal <= wdata[15:0] & MASK_V;
               lv.vbp    <= wdata[31:16] & MASK;
            end
            A_SYNC: begin
               lv.hsw <= wdata[15:0] & MASK;
               lv.vsw <= wdata[31:16] & MASK;
            end
            A_POL: begin
               pol_h <= wdata[0];
               pol_v <= wdata[1];
            end
            A_TRI: tri_st <= wdata[0];
            A_INT: int_en <= wdata[0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) int_stat <= 1'b0;
      else        int_stat <= blank_set | (int_stat & !int_clr);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh <= '0;
      end else if (load) begin
         sh        <= lv;
         sh.vtotal <= lv.vtotal >> 1;
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         A_GLOBAL: rdata[0] = g_en;
         A_CHAN:   rdata    = {23'd0, clk_dly, 3'd0, c_en};
         A_ACTIVE: rdata    = {lv.height, lv.width};
         A_HTIM:   rdata    = {lv.hbp, lv.htotal};
         A_VTIM:   rdata    = {lv.vbp, lv.vtotal};
         A_SYNC:   rdata    = {lv.vsw, lv.hsw};
         A_POL:    rdata[1:0] = {pol_v, pol_h};
         A_TRI:    rdata[0] = tri_st;
         A_INT: begin
            rdata[0] = int_en;
            rdata[8] = int_stat;
         end
         default:  rdata = '0;
      endcase
   end

endmodule

// File: rtl/lcd_timing_ctrl.sv
module lcd_timing_ctrl
   import ltc_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [3:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              lcd_hsync,
   output logic              lcd_vsync,
   output logic              lcd_de,
   output logic [CNT_W-1:0]  pix_x,
   output logic [CNT_W-1:0]  pix_y,
   output logic              pad_oe,
   output logic              irq_o
);

   localparam int CW = FIELD_W + 1;

   generate
      if (CNT_W < 4 || CNT_W > FIELD_W - 1) begin : g_bad_width
         $error("lcd_timing_ctrl: CNT_W must lie in 4..15");
      end
   endgenerate

   raster_t          sh;
   logic             g_en, c_en, pol_h, pol_v, tri_st, int_en, int_stat;
   logic             run, frame_end, load, blank_set;
   logic [CNT_W-1:0] h_cnt, v_cnt, h_pos, v_pos;
   logic             h_last, v_last, h_sync, v_sync, h_act, v_act;

   assign run       = g_en & c_en;
   assign frame_end = run & h_last & v_last;
   assign load      = ~run | frame_end;
   assign blank_set = run && (h_cnt == '0) &&
                      (CW'(v_cnt) == CW'(sh.vbp) + CW'(sh.height));

   ltc_regs #(.CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .rdata(bus_rdata), .load(load),
      .blank_set(blank_set), .sh(sh), .g_en(g_en), .c_en(c_en),
      .pol_h(pol_h), .pol_v(pol_v), .tri_st(tri_st),
      .int_en(int_en), .int_stat(int_stat)
   );

   ltc_axis #(.CNT_W(CNT_W)) u_hax (
      .clk(clk), .rst_n(rst_n), .run(run), .step(1'b1),
      .total(sh.htotal), .bp(sh.hbp), .act_len(sh.width), .sync_len(sh.hsw),
      .cnt(h_cnt), .last(h_last), .in_sync(h_sync), .in_act(h_act), .pos(h_pos)
   );

   ltc_axis #(.CNT_W(CNT_W)) u_vax (
      .clk(clk), .rst_n(rst_n), .run(run), .step(h_last),
      .total(sh.vtotal), .bp(sh.vbp), .act_len(sh.height), .sync_len(sh.vsw),
      .cnt(v_cnt), .last(v_last), .in_sync(v_sync), .in_act(v_act), .pos(v_pos)
   );

   assign lcd_de    = h_act & v_act;
   assign pix_x     = lcd_de ? h_pos : '0;
   assign pix_y     = lcd_de ? v_pos : '0;
   assign lcd_hsync = h_sync ^ pol_h;
   assign lcd_vsync = v_sync ^ pol_v;
   assign pad_oe    = ~tri_st;
   assign irq_o     = int_en & int_stat;

endmodule

// File: rtl/ltc_checker.sv
module ltc_checker
   import ltc_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             frame_end,
   input raster_t          sh,
   input logic             lcd_de,
   input logic [CNT_W-1:0] pix_x,
   input logic             irq_o,
   input logic             int_en,
   input logic             int_stat,
   input logic             bus_wr,
   input logic [3:0]       bus_addr,
   input logic [31:0]      bus_wdata
);

   AST_DE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !lcd_de); // R2

   AST_X_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      lcd_de |-> (FIELD_W'(pix_x) < sh.width)); // R5

   AST_X_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (lcd_de && $past(lcd_de)) |-> (pix_x == $past(pix_x) + 1'b1)); // R5

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (int_en && int_stat)); // R9

   AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (int_stat && !(bus_wr && bus_addr == A_INT && !bus_wdata[8])) |=> int_stat); // R8

   AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !frame_end) |=> $stable(sh)); // R10

endmodule

bind lcd_timing_ctrl ltc_checker #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .run(run), .frame_end(frame_end), .sh(sh),
   .lcd_de(lcd_de), .pix_x(pix_x), .irq_o(irq_o), .int_en(int_en),
   .int_stat(int_stat), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata)
);

// File: tb/test_lcd_timing_ctrl.sv
`timescale 1ns/1ps
module test_lcd_timing_ctrl;

   localparam int CNT_W = 12;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             bus_wr = 1'b0;
   logic [3:0]       bus_addr = '0;
   logic [31:0]      bus_wdata = '0;
   logic [31:0]      bus_rdata;
   logic             lcd_hsync, lcd_vsync, lcd_de, pad_oe, irq_o;
   logic [CNT_W-1:0] pix_x, pix_y;

   int checks = 0;
   int fails  = 0;
   bit live_chk = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   lcd_timing_ctrl #(.CNT_W(CNT_W)) i_lcd_timing_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lcd_hsync(lcd_hsync),
      .lcd_vsync(lcd_vsync), .lcd_de(lcd_de), .pix_x(pix_x), .pix_y(pix_y),
      .pad_oe(pad_oe), .irq_o(irq_o)
   );

   // behavioural reference: programmed values, working copy, raster position
   int m_g, m_c, m_ph, m_pv, m_tri, m_ien, m_ist, m_dly;
   int l_w, l_hg, l_ht, l_hbp, l_vt2, l_vbp, l_hsw, l_vsw;
   int s_w, s_hg, s_ht, s_hbp, s_vt, s_vbp, s_hsw, s_vsw;
   int m_h, m_v;

   always @(posedge clk) begin
      int run, blank, fend, clr;
      if (!rst_n) begin
         m_g = 0; m_c = 0; m_ph = 0; m_pv = 0; m_tri = 1; m_ien = 0; m_ist = 0; m_dly = 0;
         l_w = 0; l_hg = 0; l_ht = 0; l_hbp = 0; l_vt2 = 0; l_vbp = 0; l_hsw = 0; l_vsw = 0;
         s_w = 0; s_hg = 0; s_ht = 0; s_hbp = 0; s_vt = 0; s_vbp = 0; s_hsw = 0; s_vsw = 0;
         m_h = 0; m_v = 0;
      end else begin
         run = m_g & m_c;
         blank = 0; fend = 0;
         if (run) begin
            blank = (m_h == 0 && m_v == s_vbp + s_hg);
            if (m_h + 1 >= s_ht) begin
               m_h = 0;
               if (m_v + 1 >= s_vt) begin m_v = 0; fend = 1; end
               else m_v++;
            end else m_h++;
         end else begin
            m_h = 0; m_v = 0;
         end
         if (!run || fend) begin
            s_w = l_w; s_hg = l_hg; s_ht = l_ht; s_hbp = l_hbp;
            s_vt = l_vt2 / 2; s_vbp = l_vbp; s_hsw = l_hsw; s_vsw = l_vsw;
         end
         clr = (bus_wr && bus_addr == 4'd8 && !bus_wdata[8]);
         m_ist = blank | (m_ist & !clr);
         if (bus_wr) begin
            case (bus_addr)
               4'd0: m_g = bus_wdata[0];
               4'd1: begin m_c = bus_wdata[0]; m_dly = bus_wdata[8:4]; end
               4'd2: begin l_w = bus_wdata[15:0]; l_hg = bus_wdata[31:16]; end
               4'd3: begin l_ht = bus_wdata[15:0]; l_hbp = bus_wdata[31:16]; end
               4'd4: begin l_vt2 = bus_wdata[15:0]; l_vbp = bus_wdata[31:16]; end
               4'd5: begin l_hsw = bus_wdata[15:0]; l_vsw = bus_wdata[31:16]; end
               4'd6: begin m_ph = bus_wdata[0]; m_pv = bus_wdata[1]; end
               4'd7: m_tri = bus_wdata[0];
               4'd8: m_ien = bus_wdata[0];
               default: ;
            endcase
         end
      end
   end

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      int run, de, eh, ev;
      if (rst_n && live_chk && !done) begin
         run = m_g & m_c;
         de  = run && m_h >= s_hbp && m_h < s_hbp + s_w && m_v >= s_vbp && m_v < s_vbp + s_hg;
         eh  = (run && m_h < s_hsw) ^ m_ph;
         ev  = (run && m_v < s_vsw) ^ m_pv;
         chk("R3 R6 R10 hsync", lcd_hsync, eh);
         chk("R4 R6 vsync", lcd_vsync, ev);
         chk("R2 R3 R4 de", lcd_de, de);
         chk("R5 pix_x", pix_x, de ? m_h - s_hbp : 0);
         chk("R5 pix_y", pix_y, de ? m_v - s_vbp : 0);
         chk("R9 irq", irq_o, m_ist & m_ien);
         chk("R7 pad_oe", pad_oe, !m_tri);
      end
   end

   task automatic wr(int a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(int a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = 4'(a);
      #0.5 d = bus_rdata;
   endtask

   task automatic wait_pos(int v, int h);
      do @(negedge clk); while (!(m_v == v && m_h == h));
   endtask

   task automatic count_line(output int n);
      n = 0;
      do @(negedge clk); while (!lcd_de);
      while (lcd_de) begin n++; @(negedge clk); end
   endtask

   task automatic finish_run();
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      int n, seen;
      repeat (4) @(negedge clk);
      chk("R1 de in reset", lcd_de, 0);
      chk("R1 pad_oe in reset", pad_oe, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 irq after reset", irq_o, 0);
      rd(0, d); chk("R1 global enable", d, 0);
      rd(1, d); chk("R1 channel enable", d, 0);
      rd(8, d); chk("R1 int register", d, 0);
      rd(7, d); chk("R1 tristate", d, 1);
      live_chk = 1;

      wr(2, {16'd3, 16'd4});
      wr(3, {16'd3, 16'd10});
      wr(4, {16'd2, 16'd16});
      wr(5, {16'd1, 16'd2});
      wr(7, 0);
      chk("R7 pads driven", pad_oe, 1);
      wr(1, 32'd21 << 4);
      wr(0, 1);
      seen = 0;
      repeat (40) begin @(negedge clk); if (lcd_de) seen++; end
      chk("R2 global only gives no data", seen, 0);
      wr(1, (32'd21 << 4) | 1);
      rd(1, d); chk("R11 clock delay readback", d, (21 << 4) | 1);
      count_line(n); chk("R3 active width", n, 4);
      repeat (200) @(negedge clk);
      rd(8, d); chk("R8 status set after blank", d, (m_ist << 8) | m_ien);
      chk("R8 status is set", d[8], 1);
      wr(8, 32'h101);
      rd(8, d); chk("R8 R9 write one keeps", d, 32'h101);
      chk("R9 irq raised", irq_o, 1);
      wr(8, 32'h001);
      rd(8, d); chk("R8 write zero clears", d, (m_ist << 8) | m_ien);
      repeat (100) @(negedge clk);
      wr(6, 3);
      repeat (100) @(negedge clk);
      wr(6, 0);

      wait_pos(1, 0);
      wr(2, {16'd3, 16'd6});
      wr(3, {16'd3, 16'd12});
      count_line(n); chk("R10 old width holds mid-frame", n, 4);
      wait_pos(1, 0);
      count_line(n); chk("R10 new width next frame", n, 6);
      repeat (150) @(negedge clk);

      wr(7, 1);
      chk("R7 pads released", pad_oe, 0);
      wr(0, 0);
      seen = 0;
      repeat (30) begin @(negedge clk); if (lcd_de) seen++; end
      chk("R2 disabled gives no data", seen, 0);
      finish_run();
   end

endmodule